// File: doc/BRIEF.md
# Download Memory Select Control

This block holds one control word that decides which of two parallel Z-space data memories gets the read enables. One memory is the regular store and the other is the download store. A single bit of the word routes every Z read request to one of the two read-enable outputs. A second bit is a sticky flag. It records that download mode was entered, and it stays set after the select bit is dropped. Trap or monitor software reads the flag and clears it by writing a zero to that bit position.

The remaining bits of the word are plain storage and read back exactly as written. The select history is tracked by a three-state machine:
- `SEL_REGULAR`: the select bit is 0.
- `SEL_ENTERING`: the select bit was set on the previous edge, and the flag is set at the next edge.
- `SEL_DOWNLOAD`: the select bit is 1 and the flag has already been set.

The transitions are:
- `GO_DOWNLOAD`: a write with bit 0 = 1 while in `SEL_REGULAR` moves to `SEL_ENTERING`.
- `SETTLE`: `SEL_ENTERING` moves to `SEL_DOWNLOAD` on the next edge when bit 0 stays 1.
- `ABORT`: a write with bit 0 = 0 during `SEL_ENTERING` moves to `SEL_REGULAR`.
- `GO_REGULAR`: a write with bit 0 = 0 while in `SEL_DOWNLOAD` moves to `SEL_REGULAR`.

Top module: `dlsel_ctrl`

## Requirements
- R1: After reset the whole readback word is 0: select (bit 0) is 0, the sticky flag (bit 1) is 0 and the stored upper bits are 0.
- R2: With select 0 and `zrd_req` high, only `rd_en_regular` is high.
- R3: With select 1 and `zrd_req` high, only `rd_en_download` is high.
- R4: With `zrd_req` low, both read-enable outputs are low whatever the select bit holds.
- R5: Consider a write that changes bit 0 from 0 to 1. In the cycle after that write, bit 0 reads 1 and bit 1 still holds its old value. From the cycle after that, bit 1 reads 1.
- R6: A write that clears bit 0 leaves the sticky flag at 1.
- R7: Outside the set cycle, a write with 0 in bit 1 clears the sticky flag.
- R8: A write with 1 in bit 1 never sets the sticky flag. A flag at 0 stays 0.
- R9: A single write of bit 0 = 1 and bit 1 = 0 from the regular state still sets the sticky flag one cycle later.
- R10: When a write that clears bit 1 lands in the cycle where the flag is being set, the set wins.
- R11: Bits above bit 1 read back the value of the last write.
- R12: A write with bit 0 = 1 while select is already 1 does not set the sticky flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | WORD_W | Data written to the control word |
| rd_data | output | WORD_W | Current control word readback |
| zrd_req | input | 1 | Z-space read request |
| rd_en_regular | output | 1 | Read enable of the regular memory |
| rd_en_download | output | 1 | Read enable of the download memory |

## Verification
The hardware set of the sticky flag and a software clear of that flag can fall on the same edge. This happens when a write with 0 in bit 1 arrives exactly one cycle after the write that raised the select bit. The bench provokes it with two back-to-back writes, then reads the word and expects the flag at 1. It also checks the single-write case, where the write that raises the select carries a 0 in the flag bit, and expects the flag to rise one cycle after that write.

// File: rtl/dlsel_pkg.sv
package dlsel_pkg;
    parameter int WORD_W     = 16;
    parameter int SEL_POS    = 0;
    parameter int STICKY_POS = 1;
    localparam int LOW_BITS  = 2;
    localparam int HIGH_W    = WORD_W - LOW_BITS;

    typedef enum logic [1:0] {
        SEL_REGULAR  = 2'd0,
        SEL_ENTERING = 2'd1,
        SEL_DOWNLOAD = 2'd2
    } sel_state_e;
endpackage

// File: rtl/dlsel_fsm.sv
module dlsel_fsm
    import dlsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    output sel_state_e state,
    output logic       sel_bit,
    output logic       set_pulse
);
    sel_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEL_REGULAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEL_REGULAR:  if (wr_en && wr_sel) state_nx = SEL_ENTERING;   // GO_DOWNLOAD
            SEL_ENTERING: if (wr_en && !wr_sel) state_nx = SEL_REGULAR;   // ABORT
                          else state_nx = SEL_DOWNLOAD;                   // SETTLE
            SEL_DOWNLOAD: if (wr_en && !wr_sel) state_nx = SEL_REGULAR;   // GO_REGULAR
            default:      state_nx = SEL_REGULAR;
        endcase
    end

    always_comb begin
        sel_bit   = (state != SEL_REGULAR);
        set_pulse = (state == SEL_ENTERING);
    end

    // R12: a repeated select write in download mode never re-enters the set state
    p_no_rearm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEL_DOWNLOAD) |=> (state != SEL_ENTERING));
    // R5: the entering state lasts exactly one cycle
    p_enter_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEL_ENTERING) |=> (state != SEL_ENTERING));
endmodule

// File: rtl/dlsel_sticky.sv
module dlsel_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic wr_en,
    input  logic wr_sticky,
    output logic sticky
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    sticky <= 1'b0;
        else if (set_pulse)            sticky <= 1'b1;   // hardware set has priority
        else if (wr_en && !wr_sticky)  sticky <= 1'b0;
    end

    // R10: set wins over a simultaneous clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> sticky);
    // R8: software cannot set the flag
    p_no_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky && !set_pulse) |=> !sticky);
    // R6: flag holds unless a zero is written to it
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !(wr_en && !wr_sticky)) |=> sticky);
endmodule

// File: rtl/dlsel_steer.sv
module dlsel_steer (
    input  logic sel_bit,
    input  logic zrd_req,
    output logic en_regular,
    output logic en_download
);
    always_comb begin
        en_regular  = zrd_req && !sel_bit;
        en_download = zrd_req &&  sel_bit;
    end
endmodule

// File: rtl/dlsel_ctrl.sv
module dlsel_ctrl
    import dlsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              zrd_req,
    output logic              rd_en_regular,
    output logic              rd_en_download
);
    sel_state_e        state;
    logic              sel_bit;
    logic              set_pulse;
    logic              sticky;
    logic [HIGH_W-1:0] upper_q;

    dlsel_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_data[SEL_POS]),
        .state(state), .sel_bit(sel_bit), .set_pulse(set_pulse)
    );

    dlsel_sticky u_sticky (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .wr_en(wr_en),
        .wr_sticky(wr_data[STICKY_POS]), .sticky(sticky)
    );

    dlsel_steer u_steer (
        .sel_bit(sel_bit), .zrd_req(zrd_req),
        .en_regular(rd_en_regular), .en_download(rd_en_download)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     upper_q <= '0;
        else if (wr_en) upper_q <= wr_data[WORD_W-1:LOW_BITS];
    end

    always_comb begin
        rd_data = '0;
        rd_data[WORD_W-1:LOW_BITS] = upper_q;
        rd_data[STICKY_POS]        = sticky;
        rd_data[SEL_POS]           = sel_bit;
    end

    // R2, R3, R4: at most one enable, and one whenever a request is present
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en_regular, rd_en_download}));
    p_req_served_r2: assert property (@(posedge clk) disable iff (!rst_n)
        zrd_req |-> (rd_en_regular || rd_en_download));
    // R11: upper bits track the last write
    p_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[WORD_W-1:LOW_BITS] == $past(wr_data[WORD_W-1:LOW_BITS])));
    // R5: rising select is followed by the flag
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[SEL_POS]) |=> rd_data[STICKY_POS]);
endmodule

// File: tb/dlsel_ctrl_tb_top.sv
`timescale 1ns/1ps
module dlsel_ctrl_tb_top;
    localparam int W = 16;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [W-1:0] wr_data;
    logic [W-1:0] rd_data;
    logic         zrd_req;
    logic         rd_en_regular;
    logic         rd_en_download;
    int           n_chk = 0;
    int           n_bad = 0;

    always #5 clk = ~clk;

    dlsel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .zrd_req(zrd_req),
        .rd_en_regular(rd_en_regular), .rd_en_download(rd_en_download)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, one edge consumes the write, returns at next negedge
    task automatic wr(input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset_r1();
        chk("R1 word", rd_data, 16'h0000);
        zrd_req = 1'b1; #1;
        chk("R2 regular en", {14'd0, rd_en_download, rd_en_regular}, 16'h0001);
        zrd_req = 1'b0;
    endtask

    task automatic t_steer_r2_r3_r4();
        zrd_req = 1'b0; #1;
        chk("R4 no req sel0", {14'd0, rd_en_download, rd_en_regular}, 16'h0000);
        wr(16'h0001);
        zrd_req = 1'b1; #1;
        chk("R3 download en", {14'd0, rd_en_download, rd_en_regular}, 16'h0002);
        zrd_req = 1'b0; #1;
        chk("R4 no req sel1", {14'd0, rd_en_download, rd_en_regular}, 16'h0000);
        wr(16'h0002);  // drop select, keep flag
        zrd_req = 1'b1; #1;
        chk("R2 back to regular", {14'd0, rd_en_download, rd_en_regular}, 16'h0001);
        zrd_req = 1'b0;
        wr(16'h0000);  // clear flag
    endtask

    task automatic t_timing_r5_r6_r7();
        wr(16'h0003);
        chk("R5 select up, flag old", rd_data[1:0], 2'b01);
        idle();
        chk("R5 flag set next cycle", rd_data[1:0], 2'b11);
        wr(16'h0002);
        chk("R6 flag survives select clear", rd_data[1:0], 2'b10);
        idle();
        chk("R6 flag still held", rd_data[1:0], 2'b10);
        wr(16'h0000);
        chk("R7 zero write clears flag", rd_data[1:0], 2'b00);
    endtask

    task automatic t_nosw_r8();
        wr(16'h0002);
        chk("R8 sw write of 1 ignored", rd_data[1:0], 2'b00);
        idle();
        chk("R8 still clear", rd_data[1:0], 2'b00);
    endtask

    task automatic t_single_r9();
        wr(16'h0001);
        chk("R9 flag not yet", rd_data[1:0], 2'b01);
        idle();
        chk("R9 flag set one cycle later", rd_data[1:0], 2'b11);
    endtask

    task automatic t_collide_r10();
        wr(16'h0000);
        chk("R7 clean start", rd_data[1:0], 2'b00);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h0001;
        @(negedge clk);
        wr_data = 16'h0001;  // second write clears bit 1 on the set edge
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 set beats clear", rd_data[1:0], 2'b11);
    endtask

    task automatic t_rearm_r12();
        wr(16'h0001);  // select stays 1, flag cleared
        chk("R12 flag cleared with select up", rd_data[1:0], 2'b01);
        wr(16'h0001);
        idle();
        chk("R12 repeated select no re-set", rd_data[1:0], 2'b01);
    endtask

    task automatic t_upper_r11();
        wr(16'hA5F0);
        chk("R11 upper bits", rd_data & 16'hFFFC, 16'hA5F0);
        wr(16'h5A0C);
        chk("R11 upper bits second", rd_data & 16'hFFFC, 16'h5A0C);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; zrd_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_steer_r2_r3_r4();
        t_timing_r5_r6_r7();
        t_nosw_r8();
        t_single_r9();
        t_collide_r10();
        t_rearm_r12();
        t_upper_r11();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule